// File: doc/BRIEF.md
# Boundary-Scan Pin Register Chain

This block is the data-register side of a boundary-scan test port for a group of bidirectional pins. Every pin carries three scan cells: one watches the pad input level, one stands in the path of the output data and one stands in the path of the output enable. Each cell has a shift stage, which captures and shifts serially from `tdi` towards `tdo`, and an update stage, which holds a value that can be driven onto the pad. A test controller outside the block decodes the TAP states and supplies the capture, shift and update strobes and an instruction select.

With the observe/preload instruction selected, the core keeps driving the pads. The chain only captures what it sees, and it can load update-stage values ahead of a later test. With the external-test instruction selected, the update stage takes over pad data and pad enable at once, so that fixed levels can be forced onto the board wiring and the results captured back.

A device-wide output enable, when low, tristates every pad. It does not alter what the enable cells record from the core.

Top module: `bscan_chain`

## Requirements
- R1: When `trstN` is low, every shift stage, every update stage and `tdo` clear to 0. After reset, selecting external test therefore gives `padOe` all 0 and `padOut` all 0.
- R2: While `extestSel` is 0 (observe/preload), `padOut` equals `coreOut` and `padOe` equals `coreOe & devOe`. This holds whatever the update stages contain.
- R3: While `extestSel` is 1 (external test), `padOut[p]` equals the update-stage data of pin p and `padOe[p]` equals the update-stage enable of pin p ANDed with `devOe`.
- R4: On a rising `tck` edge with `captureDr` high, cell 3p loads `padIn[p]`. Cells 3p+1 and 3p+2 load the selected data and enable: `coreOut[p]`/`coreOe[p]` under observe/preload, and the update-stage data/enable under external test.
- R5: On a rising edge with `shiftDr` high, the chain moves one place towards `tdo` and `tdi` enters cell 3N-1. Bits leave in cell order 0,1,2,…, so pin 0's input, output and enable cells come out first. A bit entered on `tdi` reaches `tdo` only after all 3N captured bits have left.
- R6: `tdo` changes only on falling `tck` edges. It shows cell 0 of the chain as it stood after the preceding rising edge.
- R7: On a rising edge with `updateDr` high, update data of pin p takes cell 3p+1 and update enable takes cell 3p+2. At all other times, capture and shift included, the update stages hold.
- R8: When `devOe` is 0, all `padOe` bits are 0. Enable cells still capture the selected enable value, not 0.
- R9: Values preloaded under observe/preload appear on the pads in the same cycle `extestSel` rises, with no strobe needed.
- R10: Under external test, a pin whose update enable is 0 is tristated, and its input cell captures the level the board drives onto it.
- R11: When several strobes are high on one edge, capture takes precedence over shift, and shift over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe |
| extestSel | input | 1 | 1 = external test, 0 = observe/preload |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| devOe | input | 1 | Device-wide output enable, active high |
| coreOut | input | NUM_PINS | Core output data per pin |
| coreOe | input | NUM_PINS | Core output enable per pin |
| padIn | input | NUM_PINS | Level seen at each pad |
| padOut | output | NUM_PINS | Data to pad drivers |
| padOe | output | NUM_PINS | Enable to pad drivers |

## Verification
The bench models the pads as a loopback. Enabled pins read back their own drive, and tristated pins read a level forced by the bench, so a wrong input cell or a wrong enable shows up as a captured-bit mismatch. It checks that preloaded values land on the pads the moment external test is selected, and that they stay put during a full capture and shift until the update strobe arrives. A design that drove from the update stage under observe/preload, or that updated during shifting, would show the wrong pad values there. It reads `tdo` on both sides of each rising edge to catch a rising-edge output stage, and counts 3N shifts before the first `tdi` bit appears to catch a chain that is too short or in the wrong order. It also pulses capture and shift together to catch a reversed strobe priority, and drops `devOe` to catch enable cells that record the forced tristate instead of the core's request.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic extest;
  } scanCtrl_t;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  input  logic      extestSel,
  output scanCtrl_t ctrl
);
  // capture beats shift beats update
  always_comb begin
    ctrl.capture = captureDr;
    ctrl.shift   = shiftDr & ~captureDr;
    ctrl.update  = updateDr & ~captureDr & ~shiftDr;
    ctrl.extest  = extestSel;
  end

  AST_ONE_STROBE: assert property (@(posedge tck) disable iff (!trstN)
    $countones({ctrl.capture, ctrl.shift, ctrl.update}) <= 1) else $error("strobe overlap"); // R11
  AST_CAPTURE_WINS: assert property (@(posedge tck) disable iff (!trstN)
    captureDr |-> !ctrl.shift && !ctrl.update) else $error("capture lost"); // R11
endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                tck,
  input  logic                trstN,
  input  scanCtrl_t           ctrl,
  input  logic                tdi,
  output logic                tdo,
  input  logic                devOe,
  input  logic [NUM_PINS-1:0] coreOut,
  input  logic [NUM_PINS-1:0] coreOe,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  localparam int CELLS = 3 * NUM_PINS;

  logic [CELLS-1:0]    shiftReg;
  logic [CELLS-1:0]    capVec;
  logic [NUM_PINS-1:0] updOut, updOe;
  logic [NUM_PINS-1:0] selOut, selOe;
  logic [NUM_PINS-1:0] inCellView;

  // pad-drive selection: update stage only under external test
  assign selOut = ctrl.extest ? updOut : coreOut;
  assign selOe  = ctrl.extest ? updOe  : coreOe;
  assign padOut = selOut;
  assign padOe  = selOe & {NUM_PINS{devOe}};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign capVec[3*p]   = padIn[p];
    assign capVec[3*p+1] = selOut[p];
    assign capVec[3*p+2] = selOe[p];
    assign inCellView[p] = shiftReg[3*p];

    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN) begin
        updOut[p] <= 1'b0;
        updOe[p]  <= 1'b0;
      end else if (ctrl.update) begin
        updOut[p] <= shiftReg[3*p+1];
        updOe[p]  <= shiftReg[3*p+2];
      end
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            shiftReg <= '0;
    else if (ctrl.capture) shiftReg <= capVec;
    else if (ctrl.shift)   shiftReg <= {tdi, shiftReg[CELLS-1:1]};
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdo <= 1'b0;
    else        tdo <= shiftReg[0];
  end

  AST_CAPTURE_PIN: assert property (@(posedge tck) disable iff (!trstN)
    ctrl.capture |=> inCellView == $past(padIn)) else $error("input cell capture"); // R4
  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!trstN)
    ctrl.shift |=> shiftReg[CELLS-2:0] == $past(shiftReg[CELLS-1:1])) else $error("shift step"); // R5
  AST_UPD_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    !ctrl.update |=> $stable(updOut) && $stable(updOe)) else $error("update moved"); // R7
  AST_DEV_OFF: assert property (@(posedge tck) disable iff (!trstN)
    !devOe |-> padOe == '0) else $error("pad enabled while device off"); // R8
  AST_SAMPLE_PASS: assert property (@(posedge tck) disable iff (!trstN)
    !ctrl.extest |-> padOut == coreOut) else $error("sample forced pins"); // R2
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                extestSel,
  input  logic                tdi,
  output logic                tdo,
  input  logic                devOe,
  input  logic [NUM_PINS-1:0] coreOut,
  input  logic [NUM_PINS-1:0] coreOe,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  scanCtrl_t ctrl;

  bscan_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .extestSel(extestSel), .ctrl(ctrl)
  );

  bscan_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .tck(tck), .trstN(trstN), .ctrl(ctrl), .tdi(tdi), .tdo(tdo),
    .devOe(devOe), .coreOut(coreOut), .coreOe(coreOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/sim_bscan_chain.sv
`timescale 1ns/1ps
module sim_bscan_chain;
  localparam int N = 4;
  localparam int L = 3 * N;

  logic tck = 1'b0, trstN = 1'b0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, extestSel = 0, tdi = 0, devOe = 1;
  logic [N-1:0] coreOut = '0, coreOe = '0, extDrive = '0;
  logic [N-1:0] padIn, padOut, padOe;
  logic tdo;
  logic [N-1:0] mUpdOut = '0, mUpdOe = '0;
  int nTests = 0, nFail = 0;
  bit done = 0;

  always #10 tck = ~tck; // 50 MHz

  // board model: enabled pins read back their drive, others read extDrive
  assign padIn = (padOe & padOut) | (~padOe & extDrive);

  bscan_chain #(.NUM_PINS(N)) u0 (
    .tck(tck), .trstN(trstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .extestSel(extestSel), .tdi(tdi), .tdo(tdo),
    .devOe(devOe), .coreOut(coreOut), .coreOe(coreOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] expCap(input logic ext);
    logic [L-1:0] v;
    for (int p = 0; p < N; p++) begin
      v[3*p]   = padIn[p];
      v[3*p+1] = ext ? mUpdOut[p] : coreOut[p];
      v[3*p+2] = ext ? mUpdOe[p]  : coreOe[p];
    end
    return v;
  endfunction

  // capture (optionally with shift high too), then L shifts; returns captured bits and first tdi bit back
  task automatic scan(input logic [L-1:0] din, input logic alsoShift,
                      output logic [L-1:0] got, output logic firstBack);
    captureDr = 1; shiftDr = alsoShift;
    @(posedge tck); #1 captureDr = 0; shiftDr = 0;
    for (int i = 0; i < L; i++) begin
      @(negedge tck); #2 got[i] = tdo; tdi = din[i]; shiftDr = 1;
      @(posedge tck); #1;
      check(tdo === got[i], "R6", tdo, got[i]);
    end
    shiftDr = 0;
    @(negedge tck); #2 firstBack = tdo;
  endtask

  task automatic doUpdate(input logic [L-1:0] din);
    updateDr = 1;
    @(posedge tck); #1 updateDr = 0;
    for (int p = 0; p < N; p++) begin
      mUpdOut[p] = din[3*p+1];
      mUpdOe[p]  = din[3*p+2];
    end
  endtask

  task automatic tReset();
    #3;
    check(tdo === 1'b0, "R1 tdo", tdo, 0);
    extestSel = 1; #1;
    check(padOe === '0 && padOut === '0, "R1 pads", {padOe, padOut}, 0);
    extestSel = 0;
    trstN = 1;
    @(posedge tck); #1;
  endtask

  task automatic tSample();
    logic [L-1:0] got, exp, din;
    logic fb;
    coreOut = 4'b1010; coreOe = 4'b0110; #1;
    check(padOut === coreOut && padOe === coreOe, "R2 a", {padOe, padOut}, {coreOe, coreOut});
    coreOut = 4'b0101; coreOe = 4'b1011; #1;
    check(padOut === coreOut && padOe === coreOe, "R2 b", {padOe, padOut}, {coreOe, coreOut});
    exp = expCap(1'b0);
    din = 12'b110_011_101_010; // enable,output,input per pin, pin3..pin0
    scan(din, 1'b0, got, fb);
    check(got === exp, "R4/R5 sample capture", got, exp);
    check(fb === din[0], "R5 tdi after 3N", fb, din[0]);
    doUpdate(din);
    check(padOut === coreOut && padOe === coreOe, "R2 after preload", {padOe, padOut}, {coreOe, coreOut});
  endtask

  task automatic tExtest();
    logic [L-1:0] got, exp, din;
    logic fb;
    extDrive = 4'b1101;
    extestSel = 1; #1;
    check(padOut === mUpdOut && padOe === mUpdOe, "R9/R3 preload drive", {padOe, padOut}, {mUpdOe, mUpdOut});
    exp = expCap(1'b1);
    check(((padIn ^ extDrive) & ~mUpdOe) === '0, "R10 tristated pins read board", padIn, extDrive);
    din = 12'b011_110_001_100;
    scan(din, 1'b0, got, fb);
    check(got === exp, "R4/R10 extest capture", got, exp);
    check(padOut === mUpdOut && padOe === mUpdOe, "R7 hold during shift", {padOe, padOut}, {mUpdOe, mUpdOut});
    doUpdate(din);
    check(padOut === mUpdOut && padOe === mUpdOe, "R7/R3 after update", {padOe, padOut}, {mUpdOe, mUpdOut});
  endtask

  task automatic tDevOff();
    logic [L-1:0] got, exp;
    logic fb;
    extestSel = 0; devOe = 0; coreOe = 4'b1111; coreOut = 4'b0011; extDrive = 4'b1000; #1;
    check(padOe === '0, "R8 tristate", padOe, 0);
    exp = expCap(1'b0);
    scan('0, 1'b0, got, fb);
    check(got === exp, "R8 enable cells keep core", got, exp);
    devOe = 1;
  endtask

  task automatic tPriority();
    logic [L-1:0] got, exp;
    logic fb;
    coreOut = 4'b1001; coreOe = 4'b0101; #1;
    exp = expCap(1'b0);
    scan('1, 1'b1, got, fb);
    check(got === exp, "R11 capture over shift", got, exp);
  endtask

  initial begin
    #150000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    tReset();
    tSample();
    tExtest();
    tDevOff();
    tPriority();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule